// File: doc/BRIEF.md
# Sample correction pipeline

This block corrects a stream of raw signed converter samples on their way to storage. A two's-complement offset is first added to each sample. The sum is then scaled by an unsigned fixed-point gain with fifteen fraction bits. The scaled value is clamped to the signed 16-bit range, and the result is finally limited to a symmetric window of plus or minus a programmable 15-bit magnitude. The block accepts one sample per clock and returns it, corrected, a fixed number of cycles later, with a valid flag that travels alongside it.

The offset, gain and limit travel with each sample. They are captured in the same cycle as the sample they apply to, so a change of coefficients between two back-to-back samples affects only the later sample. Each clamp stage classifies its input into one of three regions: `LIM_PASS` (in range, passed through), `LIM_HIGH` (above the upper bound, replaced by it) and `LIM_LOW` (below the lower bound, replaced by it). The choice is made again for every sample. There are no stored states and no transitions between samples. When all coefficients are left at zero, the output stays at zero.

Top module: `smp_corr_pipe`

## Requirements
- R1: An input sample taken with `smp_vld_i` high at clock edge t appears on `corr_o`, with `corr_vld_o` high, after clock edge t+2 (three register stages). `corr_vld_o` is low for every cycle in which no sample was accepted three edges earlier.
- R2: The offset is added to the sample before the gain is applied: the result is floor((sample + offset) * gain / 32768) before clamping.
- R3: The gain is an unsigned 16-bit value with 15 fraction bits: 0x8000 is a gain of exactly one, 0x4000 is one half and 0xC000 is one and a half.
- R4: The scaled value is truncated toward negative infinity. With a gain of one half, +1 gives 0, -1 gives -1 and -3 gives -2.
- R5: The scaled value is first clamped to the range -32768 to +32767, and then passed to the programmable limit.
- R6: The output is limited to the range from minus the 15-bit limit to plus the limit. With limit 0x7FFF, the most negative output is -32767.
- R7: A gain of zero or a limit of zero gives an output of zero.
- R8: The offset, gain and limit used for a sample are those present in the cycle the sample is accepted. Samples may arrive in consecutive cycles with different coefficients.
- R9: While `corr_vld_o` is low, `corr_o` holds the last corrected value.
- R10: Low-order bits are not masked: with unity gain, zero offset and full limit, an input of 3 gives an output of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Input sample valid |
| smp_i | input | DATA_W | Raw signed sample |
| offset_i | input | DATA_W | Signed offset added to the sample |
| gain_i | input | DATA_W | Unsigned gain, 0x8000 is unity |
| sat_lim_i | input | DATA_W-1 | Unsigned magnitude of the symmetric output limit |
| corr_vld_o | output | 1 | Corrected sample valid |
| corr_o | output | DATA_W | Corrected signed sample |

## Verification
On every cycle, the assertions check that valid flags are delayed by exactly three edges, that a corrected output never leaves the window of its own captured limit, that data holds while idle, that a zero gain or zero limit forces zero, and that unity settings pass the sample through unchanged. Other behaviour can only be seen in directed scenarios: the order of offset and gain, floor rounding of negative fractions, the fixed clamp at both rails combined with the programmable limit, and per-sample capture of coefficients under a back-to-back stream.

// File: rtl/smp_corr_pkg.sv
package smp_corr_pkg;

    // Region a clamp stage selects for the current sample
    typedef enum logic [1:0] {
        LIM_PASS = 2'd0,
        LIM_HIGH = 2'd1,
        LIM_LOW  = 2'd2
    } lim_sel_e;

endpackage

// File: rtl/smp_corr_offset.sv
module smp_corr_offset #(
    parameter int DATA_W = 16,
    parameter int SAT_W  = DATA_W - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic [DATA_W-1:0]    smp_i,
    input  logic [DATA_W-1:0]    off_i,
    input  logic [DATA_W-1:0]    gain_i,
    input  logic [SAT_W-1:0]     sat_i,
    output logic                 vld_o,
    output logic [DATA_W:0]      sum_o,
    output logic [DATA_W-1:0]    gain_o,
    output logic [SAT_W-1:0]     sat_o
);

    logic [DATA_W:0] sum_d;

    // sign-extend both operands by one bit so the sum never wraps
    always_comb begin
        sum_d = {smp_i[DATA_W-1], smp_i} + {off_i[DATA_W-1], off_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            sum_o  <= '0;
            gain_o <= '0;
            sat_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                sum_o  <= sum_d;
                gain_o <= gain_i;
                sat_o  <= sat_i;
            end
        end
    end

    // R8: coefficients are captured with their sample
    assert_coef_capture_R8: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> (gain_o == $past(gain_i) && sat_o == $past(sat_i)));

endmodule

// File: rtl/smp_corr_gain.sv
module smp_corr_gain #(
    parameter int DATA_W    = 16,
    parameter int SAT_W     = DATA_W - 1,
    parameter int GAIN_FRAC = DATA_W - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic [DATA_W:0]      sum_i,
    input  logic [DATA_W-1:0]    gain_i,
    input  logic [SAT_W-1:0]     sat_i,
    output logic                 vld_o,
    output logic [DATA_W+1-GAIN_FRAC+DATA_W:0] scaled_o,
    output logic [SAT_W-1:0]     sat_o
);

    localparam int SUM_W  = DATA_W + 1;
    localparam int PROD_W = SUM_W + DATA_W + 1;
    localparam int SCL_W  = PROD_W - GAIN_FRAC;

    logic signed [PROD_W-1:0] prod;
    logic [SCL_W-1:0]         scaled_d;
    logic                     unused_frac;

    // gain is unsigned: prepend a zero so the signed multiply keeps it positive
    always_comb begin
        prod        = $signed(sum_i) * $signed({1'b0, gain_i});
        // dropping fraction bits of a two's-complement value floors it
        scaled_d    = prod[PROD_W-1:GAIN_FRAC];
        unused_frac = ^prod[GAIN_FRAC-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o    <= 1'b0;
            scaled_o <= '0;
            sat_o    <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                scaled_o <= scaled_d;
                sat_o    <= sat_i;
            end
        end
    end

    // R7: a zero gain yields a zero scaled value
    assert_zero_gain_R7: assert property (@(posedge clk) disable iff (rst)
        (vld_i && gain_i == '0) |=> scaled_o == '0);

endmodule

// File: rtl/smp_corr_clamp.sv
module smp_corr_clamp
    import smp_corr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SAT_W     = DATA_W - 1,
    parameter int GAIN_FRAC = DATA_W - 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld_i,
    input  logic [2*DATA_W+2-GAIN_FRAC-1:0] scaled_i,
    input  logic [SAT_W-1:0]     sat_i,
    output logic                 vld_o,
    output logic [DATA_W-1:0]    data_o
);

    localparam int SCL_W = 2 * DATA_W + 2 - GAIN_FRAC;
    localparam logic signed [SCL_W-1:0] HI_LIM = SCL_W'((1 <<< (DATA_W - 1)) - 1);
    localparam logic signed [SCL_W-1:0] LO_LIM = SCL_W'(-(1 <<< (DATA_W - 1)));

    lim_sel_e                  fix_sel;
    lim_sel_e                  prog_sel;
    logic signed [SCL_W-1:0]   scaled_s;
    logic signed [DATA_W-1:0]  fixed_v;
    logic signed [DATA_W-1:0]  lim_pos;
    logic signed [DATA_W-1:0]  lim_neg;
    logic signed [DATA_W-1:0]  final_v;

    // fixed clamp to the signed data range
    always_comb begin
        scaled_s = $signed(scaled_i);
        if (scaled_s > HI_LIM) begin
            fix_sel = LIM_HIGH;
        end else if (scaled_s < LO_LIM) begin
            fix_sel = LIM_LOW;
        end else begin
            fix_sel = LIM_PASS;
        end
        unique case (fix_sel)
            LIM_HIGH: fixed_v = HI_LIM[DATA_W-1:0];
            LIM_LOW:  fixed_v = LO_LIM[DATA_W-1:0];
            default:  fixed_v = scaled_s[DATA_W-1:0];
        endcase
    end

    // programmable symmetric limit
    always_comb begin
        lim_pos = $signed({1'b0, sat_i});
        lim_neg = -lim_pos;
        if (fixed_v > lim_pos) begin
            prog_sel = LIM_HIGH;
        end else if (fixed_v < lim_neg) begin
            prog_sel = LIM_LOW;
        end else begin
            prog_sel = LIM_PASS;
        end
        unique case (prog_sel)
            LIM_HIGH: final_v = lim_pos;
            LIM_LOW:  final_v = lim_neg;
            default:  final_v = fixed_v;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            data_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                data_o <= final_v;
            end
        end
    end

    // R6: output stays inside the window of the limit it was computed with
    assert_within_limit_R6: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> ($signed(data_o) <= $signed({1'b0, $past(sat_i)}) &&
                   $signed(data_o) >= -$signed({1'b0, $past(sat_i)})));

    // R9: data holds while no sample is passing
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(data_o));

endmodule

// File: rtl/smp_corr_pipe.sv
module smp_corr_pipe #(
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_vld_i,
    input  logic [DATA_W-1:0]    smp_i,
    input  logic [DATA_W-1:0]    offset_i,
    input  logic [DATA_W-1:0]    gain_i,
    input  logic [DATA_W-2:0]    sat_lim_i,
    output logic                 corr_vld_o,
    output logic [DATA_W-1:0]    corr_o
);

    localparam int SAT_W     = DATA_W - 1;
    localparam int GAIN_FRAC = DATA_W - 1;
    localparam int SCL_W     = 2 * DATA_W + 2 - GAIN_FRAC;
    localparam logic [DATA_W-1:0] UNITY   = DATA_W'(1 << GAIN_FRAC);
    localparam logic [DATA_W-1:0] NEG_MIN = DATA_W'(1 << (DATA_W - 1));

    logic                 s1_vld;
    logic [DATA_W:0]      s1_sum;
    logic [DATA_W-1:0]    s1_gain;
    logic [SAT_W-1:0]     s1_sat;
    logic                 s2_vld;
    logic [SCL_W-1:0]     s2_scaled;
    logic [SAT_W-1:0]     s2_sat;

    smp_corr_offset #(
        .DATA_W (DATA_W),
        .SAT_W  (SAT_W)
    ) i_offset (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (smp_vld_i),
        .smp_i  (smp_i),
        .off_i  (offset_i),
        .gain_i (gain_i),
        .sat_i  (sat_lim_i),
        .vld_o  (s1_vld),
        .sum_o  (s1_sum),
        .gain_o (s1_gain),
        .sat_o  (s1_sat)
    );

    smp_corr_gain #(
        .DATA_W    (DATA_W),
        .SAT_W     (SAT_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) i_gain (
        .clk      (clk),
        .rst      (rst),
        .vld_i    (s1_vld),
        .sum_i    (s1_sum),
        .gain_i   (s1_gain),
        .sat_i    (s1_sat),
        .vld_o    (s2_vld),
        .scaled_o (s2_scaled),
        .sat_o    (s2_sat)
    );

    smp_corr_clamp #(
        .DATA_W    (DATA_W),
        .SAT_W     (SAT_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) i_clamp (
        .clk      (clk),
        .rst      (rst),
        .vld_i    (s2_vld),
        .scaled_i (s2_scaled),
        .sat_i    (s2_sat),
        .vld_o    (corr_vld_o),
        .data_o   (corr_o)
    );

    // R1: valid is delayed by exactly three edges
    assert_vld_delay_R1: assert property (@(posedge clk) disable iff (rst)
        smp_vld_i |=> ##2 corr_vld_o);
    assert_no_spurious_vld_R1: assert property (@(posedge clk) disable iff (rst)
        !smp_vld_i |=> ##2 !corr_vld_o);

    // R7: zero limit forces zero output
    assert_zero_limit_R7: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && sat_lim_i == '0) |=> ##2 corr_o == '0);

    // R3: unity gain, no offset, full limit passes the sample unchanged
    assert_unity_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && gain_i == UNITY && offset_i == '0 && sat_lim_i == '1 &&
         smp_i != NEG_MIN) |=> ##2 corr_o == $past(smp_i, 3));

endmodule

// File: tb/test_smp_corr_pipe.sv
`timescale 1ns/1ps
module test_smp_corr_pipe;

    typedef struct {
        logic [15:0] val;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld_i = 1'b0;
    logic [15:0] smp_i = '0;
    logic [15:0] offset_i = '0;
    logic [15:0] gain_i = '0;
    logic [14:0] sat_lim_i = '0;
    logic        corr_vld_o;
    logic [15:0] corr_o;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    always #10 clk = ~clk;

    smp_corr_pipe #(.DATA_W(16)) i_smp_corr_pipe (
        .clk        (clk),
        .rst        (rst),
        .smp_vld_i  (smp_vld_i),
        .smp_i      (smp_i),
        .offset_i   (offset_i),
        .gain_i     (gain_i),
        .sat_lim_i  (sat_lim_i),
        .corr_vld_o (corr_vld_o),
        .corr_o     (corr_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    // reference from the requirements: add, scale with floor, two clamps
    function automatic logic [15:0] model(input logic [15:0] s, input logic [15:0] o,
                                          input logic [15:0] g, input logic [14:0] l);
        longint sum, p, q, lim;
        sum = longint'($signed(s)) + longint'($signed(o));
        p   = sum * longint'(g);
        q   = p >>> 15;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        lim = longint'(l);
        if (q > lim) q = lim;
        if (q < -lim) q = -lim;
        return 16'(q);
    endfunction

    // output monitor: every valid output is matched in order
    always @(negedge clk) begin
        if (!rst && corr_vld_o) begin
            if (expq.size() == 0) begin
                check("R1 unexpected output", corr_o, 16'hxxxx);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(e.req, corr_o, e.val);
            end
        end
    end

    task automatic push(input logic [15:0] s, input logic [15:0] o, input logic [15:0] g,
                        input logic [14:0] l, input logic [15:0] exp, input string req);
        exp_t e;
        @(negedge clk);
        smp_vld_i = 1'b1;
        smp_i     = s;
        offset_i  = o;
        gain_i    = g;
        sat_lim_i = l;
        e.val = exp;
        e.req = req;
        expq.push_back(e);
    endtask

    task automatic drain();
        @(negedge clk);
        smp_vld_i = 1'b0;
        repeat (5) @(negedge clk);
        total++;
        if (expq.size() != 0) begin
            bad++;
            $display("FAIL R1 missing outputs actual=%0d expected=0", expq.size());
            expq.delete();
        end
    endtask

    task automatic t_reset();
        total++;
        if (corr_vld_o !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset valid actual=%0b expected=0", corr_vld_o);
        end
        check("R9 reset data", corr_o, 16'h0000);
    endtask

    task automatic t_latency();
        int cyc;
        exp_t e;
        @(negedge clk);
        smp_vld_i = 1'b1; smp_i = 16'd7; offset_i = '0; gain_i = 16'h8000; sat_lim_i = 15'h7FFF;
        e.val = 16'd7; e.req = "R1 latency data";
        expq.push_back(e);
        cyc = 0;
        do begin
            @(negedge clk);
            smp_vld_i = 1'b0;
            cyc++;
        end while (!corr_vld_o && cyc < 10);
        check("R1 latency cycles", 16'(cyc), 16'd3);
        drain();
    endtask

    task automatic t_unity_lsb();
        push(16'd3, 16'd0, 16'h8000, 15'h7FFF, 16'd3, "R10 low bits kept");
        push(16'hFFF6, 16'd0, 16'h8000, 15'h7FFF, 16'hFFF6, "R3 unity negative");
        drain();
    endtask

    task automatic t_order();
        // (100+20)*1.5 = 180, not 100*1.5+20 = 170
        push(16'd100, 16'd20, 16'hC000, 15'h7FFF, 16'd180, "R2 offset before gain");
        push(16'd200, 16'hFF9C, 16'h4000, 15'h7FFF, 16'd50, "R3 half gain with negative offset");
        drain();
    endtask

    task automatic t_floor();
        push(16'd1, 16'd0, 16'h4000, 15'h7FFF, 16'd0, "R4 +0.5 floors to 0");
        push(16'hFFFF, 16'd0, 16'h4000, 15'h7FFF, 16'hFFFF, "R4 -0.5 floors to -1");
        push(16'hFFFD, 16'd0, 16'h4000, 15'h7FFF, 16'hFFFE, "R4 -1.5 floors to -2");
        drain();
    endtask

    task automatic t_fixed_clamp();
        push(16'd30000, 16'd30000, 16'h8000, 15'h7FFF, 16'd32767, "R5 positive rail");
        push(16'h8000, 16'h8000, 16'hFFFF, 15'h7FFF, 16'h8001, "R5 negative rail then limit");
        push(16'h8000, 16'd0, 16'h8000, 15'h7FFF, 16'h8001, "R6 most negative is -32767");
        drain();
    endtask

    task automatic t_prog_limit();
        push(16'd1000, 16'd0, 16'h8000, 15'd500, 16'd500, "R6 upper limit");
        push(16'hFC18, 16'd0, 16'h8000, 15'd500, 16'hFE0C, "R6 lower limit");
        push(16'd400, 16'd0, 16'h8000, 15'd500, 16'd400, "R6 inside window");
        drain();
    endtask

    task automatic t_zero();
        push(16'd1234, 16'd55, 16'h0000, 15'h7FFF, 16'd0, "R7 zero gain");
        push(16'd1234, 16'd55, 16'h8000, 15'd0, 16'd0, "R7 zero limit");
        push(16'd1234, 16'd0, 16'h0000, 15'd0, 16'd0, "R7 all coefficients zero");
        drain();
    endtask

    task automatic t_stream();
        // back to back with coefficients changing every cycle
        for (int k = 0; k < 16; k++) begin
            logic [15:0] s, o, g;
            logic [14:0] l;
            s = 16'(k * 4099 - 30000);
            o = 16'(k * 713 - 5000);
            g = 16'(k * 4321);
            l = 15'(k * 2111 + 100);
            push(s, o, g, l, model(s, o, g, l), "R8 stream per-sample coefficients");
        end
        drain();
    endtask

    task automatic t_hold();
        push(16'd321, 16'd0, 16'h8000, 15'h7FFF, 16'd321, "R9 value before idle");
        drain();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R9 hold while idle", corr_o, 16'd321);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latency();
        t_unity_lsb();
        t_order();
        t_floor();
        t_fixed_clamp();
        t_prog_limit();
        t_zero();
        t_stream();
        t_hold();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule